// File: doc/BRIEF.md
# 8-bit Prescaled Timer with Two Compare Outputs

This block is an 8-bit up-counter. A free-running clock divider feeds it, and two compare channels are attached to it. A small register bus holds the control fields, the counter, both compare values and a set of event flags. The counter advances only on a prescaled tick. Clock-select values can stop it or choose one of five divide ratios.

There are two counting modes:
- **Free-running mode:** the counter rolls over from 255 to 0 and records an overflow.
- **Clear-on-compare mode:** compare value A acts as the ceiling. The tick that finds the counter at the ceiling reloads it to zero.

Each channel raises its match flag on the tick that carries the counter away from the compared value. On that same tick it can toggle, clear or set a per-channel output bit. When a channel's output mode is nonzero, that bit replaces the general-purpose port value on the channel's pin. The pin is driven only when its direction bit selects output.

Top module: `tmr8_cmp`

## Requirements
- R1: After a synchronous reset, every register reads 0, both output bits are 0, and the counter is stopped.
- R2: The clock select is at address 1, bits 2:0. Code 1 gives a tick every clock, 2 every 8 clocks, 3 every 64, 4 every 256 and 5 every 1024; codes 0, 6 and 7 stop the counter. The divider runs freely from reset.
- R3: Free-running mode applies when control bits 1:0 are anything other than 2'b10. In this mode the counter steps from 8'hFF to 8'h00 on a tick, and that tick sets the overflow flag (flag bit 0).
- R4: On a tick where the counter equals compare A (address 3) or compare B (address 4), that channel's flag is set: bit 1 for A, bit 2 for B. The flag becomes visible as the counter leaves the value.
- R5: Clear-on-compare mode applies when control bits 1:0 equal 2'b10. In this mode, the tick that finds the counter equal to compare A loads 0 instead of incrementing, and flag A is set on that same tick. No overflow flag is raised in this mode.
- R6: The control register is at address 0. Bits 7:6 are channel A output mode, bits 5:4 are channel B output mode, and bits 1:0 are the mode field. Bits 3:2 read as 0, address 1 bits 7:3 read as 0, and unused addresses read 0.
- R7: The flag register is at address 5. Writing 1 to a flag bit clears it. A set event in the same clock as the clearing write wins.
- R8: On a channel's match tick, output mode 01 toggles that channel's output bit, 10 clears it and 11 sets it.
- R9: When a channel's output mode is 00, the pin carries the port data bit. Otherwise it carries the channel's output bit. Pin 0 belongs to A and pin 1 to B.
- R10: Each pin's enable follows its direction bit, so a pin with direction 0 is undriven whatever its mode.
- R11: A bus write to the counter (address 2) takes effect on that clock in place of any tick step. Compare detection on that tick still uses the old count.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| port_data | input | 2 | General-purpose port values for pins 0 and 1 |
| port_dir | input | 2 | Pin direction, 1 = output |
| pin_out | output | 2 | Pin value |
| pin_oe | output | 2 | Pin drive enable, 0 = high impedance |

## Verification
The counter is driven in four ways:
- Free-running at full rate across several rollovers, which separates overflow timing from match timing.
- Clear-on-compare at divide-by-8 with a small ceiling, which shows whether the reload and flag A land on the tick at the ceiling rather than one tick early.
- Each slower divide ratio followed by the stop code, which exposes a wrong tick mask.
- Back-to-back counter writes and flag clears around a compare value, which decide the write-versus-tick and set-versus-clear priorities.

The output modes toggle, clear and set are each tried with the direction bits both on and off. This separates the pin multiplexer from the enable.

// File: rtl/tmr8_cmp.sv
module tmr8_cmp #(
  parameter int CW = 8,
  parameter int PW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    bus_addr,
  input  logic          bus_wr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  input  logic [1:0]    port_data,
  input  logic [1:0]    port_dir,
  output logic [1:0]    pin_out,
  output logic [1:0]    pin_oe
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic [7:0]    ctl;
  logic [2:0]    csel;
  logic [CW-1:0] cnt, cmp_a, cmp_b;
  logic [2:0]    flg;
  logic [PW-1:0] pre;
  logic          oc_a, oc_b;
  logic          tick;

  wire wr_ctl = bus_wr && bus_addr == 3'd0;
  wire wr_sel = bus_wr && bus_addr == 3'd1;
  wire wr_cnt = bus_wr && bus_addr == 3'd2;
  wire wr_ca  = bus_wr && bus_addr == 3'd3;
  wire wr_cb  = bus_wr && bus_addr == 3'd4;
  wire wr_flg = bus_wr && bus_addr == 3'd5;

  wire [1:0] mode_a = ctl[7:6];
  wire [1:0] mode_b = ctl[5:4];
  wire       ctc    = ctl[1:0] == 2'b10;

  always_comb
    case (csel)
      3'd1:    tick = 1'b1;
      3'd2:    tick = &pre[2:0];
      3'd3:    tick = &pre[5:0];
      3'd4:    tick = &pre[7:0];
      3'd5:    tick = &pre[9:0];
      default: tick = 1'b0;
    endcase

  wire hit_a = tick && cnt == cmp_a;
  wire hit_b = tick && cnt == cmp_b;
  wire ovf   = tick && !ctc && cnt == CMAX;
  wire [2:0] set_ev = {hit_b, hit_a, ovf};

  function automatic logic oc_next(input logic [1:0] m, input logic cur);
    case (m)
      2'b01:   return ~cur;
      2'b10:   return 1'b0;
      2'b11:   return 1'b1;
      default: return cur;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl <= '0; csel <= '0; cnt <= '0; cmp_a <= '0; cmp_b <= '0;
      flg <= '0; pre <= '0; oc_a <= 1'b0; oc_b <= 1'b0;
    end else begin
      pre <= pre + 1'b1;
      if (wr_ctl) ctl <= {bus_wdata[7:4], 2'b00, bus_wdata[1:0]};
      if (wr_sel) csel <= bus_wdata[2:0];
      if (wr_ca)  cmp_a <= bus_wdata[CW-1:0];
      if (wr_cb)  cmp_b <= bus_wdata[CW-1:0];
      if (wr_cnt)
        cnt <= bus_wdata[CW-1:0];
      else if (tick)
        cnt <= (ctc && cnt == cmp_a) ? '0 : cnt + 1'b1;
      flg <= (flg & ~(wr_flg ? bus_wdata[2:0] : 3'b000)) | set_ev;
      if (hit_a) oc_a <= oc_next(mode_a, oc_a);
      if (hit_b) oc_b <= oc_next(mode_b, oc_b);
    end
  end

  always_comb
    case (bus_addr)
      3'd0:    bus_rdata = ctl;
      3'd1:    bus_rdata = {5'b0, csel};
      3'd2:    bus_rdata = 8'(cnt);
      3'd3:    bus_rdata = 8'(cmp_a);
      3'd4:    bus_rdata = 8'(cmp_b);
      3'd5:    bus_rdata = {5'b0, flg};
      default: bus_rdata = 8'h00;
    endcase

  assign pin_out[0] = (mode_a != 2'b00) ? oc_a : port_data[0];
  assign pin_out[1] = (mode_b != 2'b00) ? oc_b : port_data[1];
  assign pin_oe     = port_dir;

  a_r2_stop_holds: assert property (@(posedge clk) disable iff (rst)
    (csel == 3'd0 && !wr_cnt) |=> $stable(cnt));
  a_r3_wrap_sets_ovf: assert property (@(posedge clk) disable iff (rst)
    (tick && !ctc && cnt == CMAX && !wr_cnt) |=> (cnt == '0 && flg[0]));
  a_r5_ctc_reload: assert property (@(posedge clk) disable iff (rst)
    (tick && ctc && cnt == cmp_a && !wr_cnt) |=> (cnt == '0 && flg[1]));
  a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt == cmp_b) |=> flg[2]);
  a_r8_toggle: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt == cmp_a && mode_a == 2'b01) |=> (oc_a != $past(oc_a)));
endmodule

// File: tb/tmr8_cmp_bench.sv
`timescale 1ns/1ps
module tmr8_cmp_bench;
  logic clk = 0, rst = 1;
  logic [2:0] bus_addr = 0;
  logic bus_wr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic [1:0] port_data = 0, port_dir = 0, pin_out, pin_oe;
  int checks = 0, errors = 0;
  bit done = 0;

  tmr8_cmp u_tmr8_cmp (.clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .port_data(port_data),
    .port_dir(port_dir), .pin_out(pin_out), .pin_oe(pin_oe));

  always #2.5 clk = ~clk;

  int m_ctl, m_sel, m_cnt, m_ca, m_cb, m_fl, m_pre, m_oa, m_ob;

  function automatic int divider(int s);
    case (s) 1: return 1; 2: return 8; 3: return 64; 4: return 256; 5: return 1024;
      default: return 0; endcase
  endfunction

  function automatic int apply_mode(int m, int cur);
    if (m == 1) return 1 - cur;
    if (m == 2) return 0;
    if (m == 3) return 1;
    return cur;
  endfunction

  function automatic int model_read(int a);
    case (a) 0: return m_ctl; 1: return m_sel; 2: return m_cnt; 3: return m_ca;
      4: return m_cb; 5: return m_fl; default: return 0; endcase
  endfunction

  function automatic string tag_of(int a);
    case (a) 0, 1: return "R6"; 2: return "R2"; 3, 4: return "R4";
      5: return "R7"; default: return "R6"; endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_ctl = 0; m_sel = 0; m_cnt = 0; m_ca = 0; m_cb = 0; m_fl = 0; m_pre = 0; m_oa = 0; m_ob = 0;
    end else begin
      int d, nc, fl;
      bit tk, is_ctc;
      d = divider(m_sel);
      tk = d != 0 && (m_pre % d) == d - 1;
      is_ctc = (m_ctl & 3) == 2;
      nc = m_cnt; fl = m_fl;
      if (bus_wr && bus_addr == 5) fl = fl & ~bus_wdata[2:0];
      if (tk) begin
        if (m_cnt == m_ca) begin fl |= 2; m_oa = apply_mode((m_ctl >> 6) & 3, m_oa); end
        if (m_cnt == m_cb) begin fl |= 4; m_ob = apply_mode((m_ctl >> 4) & 3, m_ob); end
        if (!is_ctc && m_cnt == 255) fl |= 1;
        nc = (is_ctc && m_cnt == m_ca) ? 0 : (m_cnt + 1) % 256;
      end
      m_pre = (m_pre + 1) % 1024;
      if (bus_wr) case (bus_addr)
        0: m_ctl = bus_wdata & 8'hF3;
        1: m_sel = bus_wdata & 7;
        2: nc = bus_wdata;
        3: m_ca = bus_wdata;
        4: m_cb = bus_wdata;
        default: ;
      endcase
      m_cnt = nc; m_fl = fl;
    end
    #2;
    if (!rst) begin
      check(tag_of(bus_addr), bus_rdata, model_read(bus_addr));
      check("R9", pin_out[0], ((m_ctl >> 6) & 3) != 0 ? m_oa : port_data[0]);
      check("R9", pin_out[1], ((m_ctl >> 4) & 3) != 0 ? m_ob : port_data[1]);
      check("R10", pin_oe, port_dir);
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk); bus_addr = 3'(a); bus_wdata = 8'(d); bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask
  task automatic idle(int n); repeat (n) @(negedge clk); endtask
  task automatic look(int a, int n);
    @(negedge clk); bus_addr = 3'(a); idle(n);
  endtask
  task automatic rd_now(string tag, int a, int exp);
    @(negedge clk); bus_addr = 3'(a); #0.5; check(tag, bus_rdata, exp);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3); rst = 0;
    // R1: reset values
    for (int a = 0; a < 8; a++) rd_now("R1", a, 0);
    check("R1", pin_out, 0);
    // R3 and R4: free-running at full rate
    wr(3, 5); wr(4, 9); port_dir = 2'b11; port_data = 2'b01;
    wr(1, 1);
    look(2, 40); look(5, 300);
    rd_now("R3", 5, 7);
    wr(5, 7); look(5, 3);
    // R11 and R7: counter writes next to compare B, repeated clears
    wr(4, 12); wr(2, 10);
    for (int i = 0; i < 6; i++) wr(5, 4);
    look(5, 5); wr(2, 8'hFE); look(5, 4);
    // R5 and R8: clear-on-compare at divide-by-8, A toggles, B sets
    wr(5, 7); wr(3, 20); wr(4, 3); wr(0, 8'h72); wr(1, 2);
    look(2, 200); look(5, 200); port_dir = 2'b01; look(0, 100);
    // R8: A clears, B toggles; then A sets, B clears
    wr(0, 8'h92); look(2, 300); port_dir = 2'b10;
    wr(0, 8'hE2); look(5, 300);
    // R2: slow ratios and stop
    wr(0, 8'h00); port_dir = 2'b11;
    wr(1, 3); look(2, 700);
    wr(1, 4); look(2, 1100);
    wr(1, 5); look(2, 2200);
    wr(1, 0); look(2, 300);
    wr(1, 6); look(2, 100);
    // R6: reserved bits
    wr(0, 8'hFF); rd_now("R6", 0, 8'hF3);
    wr(1, 8'hFF); rd_now("R6", 1, 8'h07);
    rd_now("R6", 7, 0);
    wr(0, 8'h00); port_data = 2'b10; look(0, 5);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule